// File: doc/BRIEF.md
# Priority Interrupt Presenter Context

This block keeps the interrupt state of one hardware thread and decides when that thread's exception line is asserted. An upstream router delivers notifications that each carry a priority. The block records each one in an eight-entry pending mask and continuously derives the most favored pending level from it. Software running on the thread sets a current priority threshold through a write port. When the most favored pending level is numerically below that threshold, the block latches an exception flag and drives its level-sensitive interrupt line.

The thread takes an interrupt with an acknowledge strobe. On the next cycle the block presents a 16-bit word. The word carries the status byte as it was before the acknowledge, together with the threshold that results from it. If an exception was latched, the acknowledge promotes the pending level into the threshold, retires that level from the pending mask and drops the exception flag, all in one step. Event queues, routing tables and bus decoding sit outside this block.

Top module: `prio_presenter_ctx`

## Requirements
- R1: After reset the pending mask is empty, the current priority is 0x00, the exception flag and `irqOut` are low and `ackValid` is low. An acknowledge issued straight after reset returns 0x0000. Writing 0xFF as the first threshold raises no interrupt.
- R2: A notification with priority p in 0..7 marks level p as pending, which is bit (7-p) of the pending mask. A notification with priority 8..15 changes no state.
- R3: The derived pending priority is the lowest pending level, which is the leading-zero count of the pending mask. It is 0xFF when nothing is pending.
- R4: The exception flag is set when, after the updates of a cycle, the derived pending priority is strictly below the current priority. Equal values do not set it. A threshold of 0xFF lets any pending level through, and 0x00 blocks all levels.
- R5: The status byte holds the exception flag in bit 7, and bits 6:0 always read as zero. `irqOut` equals the exception flag.
- R6: `ackValid` is high exactly one cycle after `ackEn`. `ackData[15:8]` is the status byte from before the acknowledge, and `ackData[7:0]` is the current priority after the acknowledge.
- R7: An acknowledge while the exception flag is set does four things: it loads the derived pending priority into the current priority, clears that level's pending bit, recomputes the derived priority and clears the exception flag. The returned priority is therefore in 0..7.
- R8: An acknowledge while the exception flag is clear leaves the pending mask and the current priority unchanged. With no other input active, `irqOut` is low in the following cycle.
- R9: When a notification and an acknowledge arrive in the same cycle, the acknowledge is applied first. The new pending bit is merged after it, and the comparison uses the merged state.
- R10: A threshold write loads all 8 bits of `cpprWrData`. In a cycle that also carries an acknowledge, the write is applied after the acknowledge, and the returned word still shows the acknowledge result. Lowering the threshold does not clear an exception that is already latched.
- R11: All state, including `irqOut`, is registered. The effect of any input shows on the outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| notifyValid | input | 1 | Notification strobe |
| notifyPrio | input | 4 | Notification priority (0..7 valid, 8..15 ignored) |
| cpprWrEn | input | 1 | Current-priority write strobe |
| cpprWrData | input | 8 | New current priority |
| ackEn | input | 1 | Acknowledge-load strobe |
| ackValid | output | 1 | Acknowledge word valid |
| ackData | output | 16 | {status before acknowledge, resulting current priority} |
| irqOut | output | 1 | Level-sensitive exception line |

## Verification
The bench first drives directed sequences. Notifications at valid and out-of-range priorities show whether decoding and ignoring work. Notifications equal to the threshold, below it and above it separate strict from non-strict comparison. Acknowledges with the flag set and with it clear show whether promotion happens only when it should. Same-cycle acknowledge-plus-notify and acknowledge-plus-write cases show that the merge order is right. A long random phase then mixes all strobes so that multiple pending levels build up. This exposes errors in the leading-zero selection and in retiring the correct bit. A behavioural model compares `irqOut`, `ackValid` and `ackData` on every clock.

// File: rtl/presenter_pkg.sv
package presenter_pkg;
  // Strobes from control to datapath, one per state-changing action.
  typedef struct packed {
    logic ackRead;      // capture acknowledge word
    logic ackTake;      // promote pending priority (flag was set)
    logic cpprLoad;     // load written threshold
    logic notifyMerge;  // merge an in-range notification
  } presenterStrobes_t;
endpackage

// File: rtl/presenter_lzc.sv
module presenter_lzc #(
  parameter int LEVELS = 8,
  parameter int OUT_W  = 8
) (
  input  logic [LEVELS-1:0] pendVec,
  output logic [OUT_W-1:0]  favored
);
  // Lowest pending level = leading zeros counted from the MSB.
  always_comb begin
    favored = '1;
    for (int p = LEVELS - 1; p >= 0; p--) begin
      if (pendVec[LEVELS-1-p]) favored = OUT_W'(p);
    end
  end
endmodule

// File: rtl/presenter_ctrl.sv
module presenter_ctrl
  import presenter_pkg::*;
#(
  parameter int LEVELS   = 8,
  parameter int NOTIFY_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                notifyValid,
  input  logic [NOTIFY_W-1:0] notifyPrio,
  input  logic                cpprWrEn,
  input  logic                ackEn,
  input  logic                hitNext,
  output presenterStrobes_t   strobes,
  output logic                excBit,
  output logic                ackValid
);
  logic prioInRange;
  logic excNext;

  assign prioInRange = (int'(notifyPrio) < LEVELS);

  always_comb begin
    strobes.ackRead     = ackEn;
    strobes.ackTake     = ackEn & excBit;
    strobes.cpprLoad    = cpprWrEn;
    strobes.notifyMerge = notifyValid & prioInRange;
  end

  // The acknowledge drops the flag first; the merged comparison may set it again.
  assign excNext = (excBit & ~ackEn) | hitNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excBit   <= 1'b0;
      ackValid <= 1'b0;
    end else begin
      excBit   <= excNext;
      ackValid <= ackEn;
    end
  end
endmodule

// File: rtl/presenter_dp.sv
module presenter_dp
  import presenter_pkg::*;
#(
  parameter int LEVELS   = 8,
  parameter int PRIO_W   = 8,
  parameter int NOTIFY_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  presenterStrobes_t     strobes,
  input  logic [NOTIFY_W-1:0]   notifyPrio,
  input  logic [PRIO_W-1:0]     cpprWrData,
  input  logic                  excBit,
  output logic                  hitNext,
  output logic [2*PRIO_W-1:0]   ackData
);
  localparam int ACK_W = 2 * PRIO_W;

  logic [LEVELS-1:0] pendBuf, pendAfterAck, pendNext, setVec, clrVec;
  logic [PRIO_W-1:0] cppr, cpprAfterAck, cpprNext;
  logic [PRIO_W-1:0] curPipr, nextPipr;

  presenter_lzc #(.LEVELS(LEVELS), .OUT_W(PRIO_W)) curLzc_i (
    .pendVec(pendBuf), .favored(curPipr));

  presenter_lzc #(.LEVELS(LEVELS), .OUT_W(PRIO_W)) nextLzc_i (
    .pendVec(pendNext), .favored(nextPipr));

  // One-hot decoders: priority p maps to bit (LEVELS-1-p).
  for (genvar i = 0; i < LEVELS; i++) begin : g_decode
    assign setVec[i] = (int'(notifyPrio) == LEVELS - 1 - i);
    assign clrVec[i] = (int'(curPipr) == LEVELS - 1 - i);
  end

  always_comb begin
    pendAfterAck = strobes.ackTake ? (pendBuf & ~clrVec) : pendBuf;
    cpprAfterAck = strobes.ackTake ? curPipr : cppr;
    cpprNext     = strobes.cpprLoad ? cpprWrData : cpprAfterAck;
    pendNext     = pendAfterAck | (strobes.notifyMerge ? setVec : '0);
  end

  assign hitNext = (nextPipr < cpprNext);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendBuf <= '0;
      cppr    <= '0;
      ackData <= '0;
    end else begin
      pendBuf <= pendNext;
      cppr    <= cpprNext;
      if (strobes.ackRead)
        ackData <= {excBit, {(PRIO_W-1){1'b0}}, cpprAfterAck};
    end
  end

  logic unusedWidth;
  assign unusedWidth = ^ACK_W;
endmodule

// File: rtl/prio_presenter_ctx.sv
module prio_presenter_ctx
  import presenter_pkg::*;
#(
  parameter int LEVELS   = 8,
  parameter int PRIO_W   = 8,
  parameter int NOTIFY_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                notifyValid,
  input  logic [NOTIFY_W-1:0] notifyPrio,
  input  logic                cpprWrEn,
  input  logic [PRIO_W-1:0]   cpprWrData,
  input  logic                ackEn,
  output logic                ackValid,
  output logic [2*PRIO_W-1:0] ackData,
  output logic                irqOut
);
  presenterStrobes_t strobes;
  logic excBit;
  logic hitNext;

  presenter_ctrl #(.LEVELS(LEVELS), .NOTIFY_W(NOTIFY_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .notifyValid(notifyValid), .notifyPrio(notifyPrio),
    .cpprWrEn(cpprWrEn), .ackEn(ackEn), .hitNext(hitNext),
    .strobes(strobes), .excBit(excBit), .ackValid(ackValid));

  presenter_dp #(.LEVELS(LEVELS), .PRIO_W(PRIO_W), .NOTIFY_W(NOTIFY_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .notifyPrio(notifyPrio),
    .cpprWrData(cpprWrData), .excBit(excBit), .hitNext(hitNext), .ackData(ackData));

  assign irqOut = excBit;
endmodule

// File: rtl/presenter_ctx_checker.sv
module presenter_ctx_checker #(
  parameter int LEVELS   = 8,
  parameter int PRIO_W   = 8,
  parameter int NOTIFY_W = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                notifyValid,
  input logic [NOTIFY_W-1:0] notifyPrio,
  input logic                cpprWrEn,
  input logic                ackEn,
  input logic                ackValid,
  input logic [2*PRIO_W-1:0] ackData,
  input logic                irqOut
);
  localparam int ACK_W = 2 * PRIO_W;

  assert_ack_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    ackEn |=> ackValid);

  assert_status_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> (ackData[ACK_W-2:PRIO_W] == '0));

  assert_ack_lowers_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ackEn && !notifyValid && !cpprWrEn) |=> !irqOut);

  assert_ignore_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    (notifyValid && (int'(notifyPrio) >= LEVELS) && !ackEn && !cpprWrEn) |=> $stable(irqOut));

  assert_rise_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(notifyValid || cpprWrEn));

  assert_taken_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && ackData[ACK_W-1]) |-> (int'(ackData[PRIO_W-1:0]) < LEVELS));
endmodule

bind prio_presenter_ctx presenter_ctx_checker #(
  .LEVELS(LEVELS), .PRIO_W(PRIO_W), .NOTIFY_W(NOTIFY_W)) chk_i (
  .clk(clk), .rstN(rstN), .notifyValid(notifyValid), .notifyPrio(notifyPrio),
  .cpprWrEn(cpprWrEn), .ackEn(ackEn), .ackValid(ackValid), .ackData(ackData),
  .irqOut(irqOut));

// File: tb/prio_presenter_ctx_tb_top.sv
module prio_presenter_ctx_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        notifyValid = 1'b0;
  logic [3:0]  notifyPrio = '0;
  logic        cpprWrEn = 1'b0;
  logic [7:0]  cpprWrData = '0;
  logic        ackEn = 1'b0;
  logic        ackValid;
  logic [15:0] ackData;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Reference model state: pending flags indexed by priority.
  bit mPend[8];
  int mCppr = 0;
  bit mExc = 0;

  always #5 clk = ~clk;

  prio_presenter_ctx dut_i (
    .clk(clk), .rstN(rstN), .notifyValid(notifyValid), .notifyPrio(notifyPrio),
    .cpprWrEn(cpprWrEn), .cpprWrData(cpprWrData), .ackEn(ackEn),
    .ackValid(ackValid), .ackData(ackData), .irqOut(irqOut));

  function automatic int mPipr();
    for (int p = 0; p < 8; p++) if (mPend[p]) return p;
    return 255;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit nv, input int np, input bit we, input int wd,
                      input bit ak, input string tag);
    int expAck;
    notifyValid = nv; notifyPrio = np[3:0];
    cpprWrEn = we; cpprWrData = wd[7:0]; ackEn = ak;
    @(posedge clk); #1;
    expAck = 0;
    if (ak) begin
      expAck = mExc ? 16'h8000 : 0;
      if (mExc) begin
        mCppr = mPipr();
        mPend[mCppr] = 0;
        mExc = 0;
      end
      expAck = expAck | mCppr;
    end
    if (we) mCppr = wd & 8'hFF;
    if (nv && (np & 15) < 8) mPend[np & 15] = 1;
    if (mPipr() < mCppr) mExc = 1;
    chk(tag, "irqOut", int'(irqOut), int'(mExc));
    chk(tag, "ackValid", int'(ackValid), int'(ak));
    if (ak) chk(tag, "ackData", int'(ackData), expAck);
    notifyValid = 0; cpprWrEn = 0; ackEn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 8; p++) mPend[p] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "irqOut in reset", int'(irqOut), 0);
    chk("R1", "ackValid in reset", int'(ackValid), 0);
    rstN = 1'b1;
    step(0, 0, 0, 0, 1, "R1");            // ack after reset returns 0x0000
    chk("R1", "ack word", int'(ackData), 16'h0000);
    step(0, 0, 1, 255, 0, "R1");          // first threshold: no interrupt
    step(1, 9, 0, 0, 0, "R2");            // out of range: ignored
    step(1, 15, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 1, "R8");            // ack, no exception
    chk("R8", "ack word", int'(ackData), 16'h00FF);
    step(1, 5, 0, 0, 0, "R4");            // 5 < 0xFF -> raise
    step(0, 0, 0, 0, 0, "R11");
    step(0, 0, 0, 0, 1, "R7");
    chk("R7", "ack word", int'(ackData), 16'h8005);
    chk("R5", "status low bits", int'(ackData[14:8]), 0);
    step(1, 5, 0, 0, 0, "R4");            // equal to threshold: no raise
    step(1, 6, 0, 0, 0, "R3");
    step(1, 2, 0, 0, 0, "R4");            // 2 < 5 -> raise
    step(0, 0, 0, 0, 1, "R7");
    chk("R7", "ack word", int'(ackData), 16'h8002);
    step(0, 0, 1, 7, 0, "R10");           // threshold 7 exposes level 5
    step(0, 0, 1, 0, 0, "R10");           // lowering keeps flag latched
    chk("R10", "irq stays", int'(irqOut), 1);
    step(1, 1, 0, 0, 1, "R9");            // ack then merge level 1
    step(0, 0, 0, 0, 1, "R9");
    step(1, 0, 1, 255, 1, "R10");         // ack, write, notify together
    step(0, 0, 0, 0, 1, "R3");
    step(0, 0, 0, 0, 1, "R3");
    step(0, 0, 0, 0, 1, "R3");
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 3) == 0, int'($urandom % 16), ($urandom % 7) == 0,
           (($urandom % 3) == 0) ? 255 : int'($urandom % 9), ($urandom % 4) == 0, "R3");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule